// File: doc/BRIEF.md
# Teletext Decoder Host Register Port

This block is the register side of a two-wire serial slave. It sits behind an existing byte-level serial interface and turns the bytes of each transfer into register writes and reads. Most registers are configuration and can only be written. Register 11 is a window into the page memory: the host loads a chapter, a row and a column into registers 8, 9 and 10, then streams bytes through register 11. Each byte moves the column on by one.

The register pointer steps forward by one with every data byte, so one transfer can load a run of registers. The pointer stops at register 11, which lets one transfer move a long run of memory bytes. A read at register 11 returns either the addressed memory byte or a status byte, chosen by bit 0 of register 0. A write at register 11 always goes to memory.

After reset a sequencer fills the whole page memory. During the fill, memory traffic from the host is held back. Register writes still go through.

Top module: `ttx_reg_port`

## Requirements
- R1: A transfer is selected only when the first byte after a start has its upper seven bits equal to 11h (22h to write, 23h to read). Bytes of any other transfer are accepted and discarded: no register changes and `h_sel` stays low.
- R2: In a write transfer, the second byte loads the register pointer. A value of 0 to 11 selects that register; any other value selects nothing. Each further byte is written to the selected register, and the pointer then advances by one. It stops advancing once it reaches 11.
- R3: In a read transfer, each `h_rd_req` is answered by a one-cycle `h_rd_valid` carrying the byte at the pointer, and the pointer advances the same way as in R2. The pointer left by an earlier write transfer is kept across a repeated start.
- R4: Registers 0 to 10 are write-only: a read from any of them returns 00h.
- R5: After reset all registers read 00h on `cfg_o`, except registers 5 and 6, which hold 03h. Register n sits at `cfg_o[8n+7:8n]`.
- R6: With register 0 bit 0 clear, a read at register 11 returns the memory byte at the active address. With it set, the read returns a status byte whose bit 0 is 1 while the fill runs, all other bits 0. A status read does not access memory and does not move the column.
- R7: A write at register 11 stores the byte to memory at the active address, whatever the value of register 0 bit 0.
- R8: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_ack`; read data is taken in the `mem_ack` cycle. `mem_addr` is {chapter, row, column}, taken from the low bits of registers 8, 9 and 10.
- R9: Each memory access through register 11 adds one to register 10. When register 10 is at NCOL-1 it returns to 0 and register 9 adds one. When register 9 is at NROW-1 it returns to 0.
- R10: After reset every memory byte is written with 20h, except chapter 0, row 0, column 7, which gets 07h.
- R11: While the fill runs, a byte aimed at register 11 is not accepted (`h_wr_ready` low), and a memory read at register 11 is not served. Writes to registers 0 to 10 complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_start | input | 1 | Pulse: start or repeated start seen |
| h_stop | input | 1 | Pulse: stop seen |
| h_wr_valid | input | 1 | Received byte is valid |
| h_wr_byte | input | 8 | Byte received from the bus master |
| h_wr_ready | output | 1 | Received byte is accepted this cycle |
| h_rd_req | input | 1 | Master asks for the next byte to send |
| h_rd_valid | output | 1 | One-cycle pulse: `h_rd_data` is valid |
| h_rd_data | output | 8 | Byte to send to the master |
| h_sel | output | 1 | Current transfer addresses this block |
| cfg_o | output | 88 | Registers 0 to 10, 8 bits each |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | CH_W+ROW_W+COL_W | {chapter, row, column} |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |

## Verification
A wrong pointer shows up on `cfg_o` right after the byte that should have landed, because the wrong register changes in that same cycle. A stale column or row shows up as a wrong `mem_addr` on the very next register 11 access. It also shows up as read data coming back in the wrong order. A fill or hold-off fault shows up as a wrong memory image or a premature `h_wr_ready`. This can only be judged after the full fill, several thousand cycles after reset.

// File: rtl/ttx_reg_pkg.sv
package ttx_reg_pkg;
  localparam int NCFG     = 11;   // write-only registers 0..10
  localparam int IDX_W    = 4;
  localparam int IDX_MODE = 0;
  localparam int IDX_CHAP = 8;
  localparam int IDX_ROW  = 9;
  localparam int IDX_COL  = 10;
  localparam int IDX_DATA = 11;

  localparam logic [7:0] FILL_BLANK = 8'h20;
  localparam logic [7:0] FILL_MARK  = 8'h07;
  localparam int         MARK_COL   = 7;

  typedef enum logic [2:0] {
    ST_SKIP,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA
  } xfer_st_e;

  function automatic logic [7:0] reg_reset_val(input int idx);
    return (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction
endpackage

// File: rtl/ttx_reg_bank.sv
module ttx_reg_bank
  import ttx_reg_pkg::*;
#(
  parameter int NROW = 26,
  parameter int NCOL = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [7:0]         wr_data,
  input  logic               col_adv,
  output logic [8*NCFG-1:0]  cfg_flat
);
  logic [7:0] col_now;
  logic [7:0] row_now;
  logic       col_last;
  logic       row_last;

  assign col_now  = cfg_flat[8*IDX_COL +: 8];
  assign row_now  = cfg_flat[8*IDX_ROW +: 8];
  assign col_last = (col_now >= 8'(NCOL - 1));
  assign row_last = (row_now >= 8'(NROW - 1));

  for (genvar i = 0; i < NCFG; i++) begin : g_reg
    logic [7:0] r_q;
    logic [7:0] r_d;
    logic       r_en;

    always_comb begin
      r_d  = r_q;
      r_en = 1'b0;
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        r_d  = wr_data;
        r_en = 1'b1;
      end
      if ((i == IDX_COL) && col_adv) begin
        r_d  = col_last ? 8'h00 : r_q + 8'h01;
        r_en = 1'b1;
      end
      if ((i == IDX_ROW) && col_adv && col_last) begin
        r_d  = row_last ? 8'h00 : r_q + 8'h01;
        r_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= reg_reset_val(i);
      else if (r_en) r_q <= r_d;
    end

    assign cfg_flat[8*i +: 8] = r_q;
  end
endmodule

// File: rtl/ttx_mem_fill.sv
module ttx_mem_fill
  import ttx_reg_pkg::*;
#(
  parameter int NCHAP = 8,
  parameter int NROW  = 26,
  parameter int NCOL  = 40,
  localparam int CH_W  = (NCHAP > 1) ? $clog2(NCHAP) : 1,
  localparam int ROW_W = $clog2(NROW),
  localparam int COL_W = $clog2(NCOL)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ack,
  output logic                         busy,
  output logic [CH_W+ROW_W+COL_W-1:0]  addr,
  output logic [7:0]                   wdata
);
  logic             busy_q, busy_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             last_col, last_row, last_ch, step;

  assign last_col = (col_q == COL_W'(NCOL - 1));
  assign last_row = (row_q == ROW_W'(NROW - 1));
  assign last_ch  = (ch_q  == CH_W'(NCHAP - 1));
  assign step     = busy_q && ack;

  always_comb begin
    busy_d = busy_q;
    ch_d   = ch_q;
    row_d  = row_q;
    col_d  = col_q;
    if (step) begin
      col_d = last_col ? '0 : col_q + 1'b1;
      if (last_col) begin
        row_d = last_row ? '0 : row_q + 1'b1;
        if (last_row) begin
          ch_d = last_ch ? '0 : ch_q + 1'b1;
          if (last_ch) busy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      ch_q   <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (step) begin
      busy_q <= busy_d;
      ch_q   <= ch_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  assign busy  = busy_q;
  assign addr  = {ch_q, row_q, col_q};
  assign wdata = (ch_q == '0 && row_q == '0 && col_q == COL_W'(MARK_COL))
                 ? FILL_MARK : FILL_BLANK;
endmodule

// File: rtl/ttx_xfer_ctrl.sv
module ttx_xfer_ctrl
  import ttx_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_start,
  input  logic             h_stop,
  input  logic             h_wr_valid,
  input  logic [7:0]       h_wr_byte,
  output logic             h_wr_ready,
  input  logic             h_rd_req,
  output logic             h_rd_valid,
  output logic [7:0]       h_rd_data,
  output logic             h_sel,
  input  logic             mode_sel,
  input  logic             fill_busy,
  output logic             reg_we,
  output logic [IDX_W-1:0] reg_idx,
  output logic [7:0]       reg_wdata,
  output logic             host_req,
  output logic             host_we,
  output logic [7:0]       host_wdata,
  input  logic             host_ack,
  input  logic [7:0]       host_rdata,
  output logic             col_adv
);
  xfer_st_e         st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d, ptr_inc;
  logic             pend_q, pend_d;
  logic             pwe_q, pwe_d;
  logic [7:0]       r11a_q, r11a_d;
  logic [7:0]       rdd_q, rdd_d;
  logic             rdv_q, rdv_d;
  logic             at11, mem_rd_sel, wr_fire, rd_fire;

  assign at11       = (ptr_q == IDX_W'(IDX_DATA));
  assign mem_rd_sel = at11 && !mode_sel;
  assign h_wr_ready = !((st_q == ST_WDATA) && at11 && (fill_busy || pend_q));
  assign wr_fire    = h_wr_valid && h_wr_ready;
  assign ptr_inc    = (ptr_q < IDX_W'(IDX_DATA)) ? ptr_q + 1'b1 : ptr_q;
  assign rd_fire    = (st_q == ST_RDATA) && h_rd_req && !rdv_q && !pend_q &&
                      !(mem_rd_sel && fill_busy);

  always_comb begin
    st_d    = st_q;
    ptr_d   = ptr_q;
    pend_d  = pend_q;
    pwe_d   = pwe_q;
    r11a_d  = r11a_q;
    rdd_d   = rdd_q;
    rdv_d   = 1'b0;
    reg_we  = 1'b0;
    col_adv = 1'b0;

    if (host_ack && pend_q) begin
      pend_d  = 1'b0;
      col_adv = 1'b1;
      if (!pwe_q) begin
        r11a_d = host_rdata;
        rdd_d  = host_rdata;
        rdv_d  = 1'b1;
      end
    end

    if (h_start) begin
      st_d = ST_ADDR;
    end else if (h_stop) begin
      st_d = ST_SKIP;
    end else if (wr_fire) begin
      case (st_q)
        ST_ADDR: begin
          if (h_wr_byte[7:1] == DEV_ADDR) st_d = h_wr_byte[0] ? ST_RDATA : ST_SUB;
          else                            st_d = ST_SKIP;
        end
        ST_SUB: begin
          ptr_d = (h_wr_byte[7:4] == 4'h0) ? h_wr_byte[3:0] : {IDX_W{1'b1}};
          st_d  = ST_WDATA;
        end
        ST_WDATA: begin
          if (at11) begin
            r11a_d = h_wr_byte;
            pend_d = 1'b1;
            pwe_d  = 1'b1;
          end else if (ptr_q < IDX_W'(IDX_DATA)) begin
            reg_we = 1'b1;
          end
          ptr_d = ptr_inc;
        end
        default: ;
      endcase
    end

    if (rd_fire) begin
      if (mem_rd_sel) begin
        pend_d = 1'b1;
        pwe_d  = 1'b0;
      end else begin
        rdd_d = at11 ? {7'b0, fill_busy} : 8'h00;
        rdv_d = 1'b1;
      end
      ptr_d = ptr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_SKIP;
      ptr_q  <= '0;
      pend_q <= 1'b0;
      pwe_q  <= 1'b0;
      r11a_q <= 8'h00;
      rdd_q  <= 8'h00;
      rdv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      pwe_q  <= pwe_d;
      r11a_q <= r11a_d;
      rdd_q  <= rdd_d;
      rdv_q  <= rdv_d;
    end
  end

  assign reg_idx    = ptr_q;
  assign reg_wdata  = h_wr_byte;
  assign host_req   = pend_q;
  assign host_we    = pwe_q;
  assign host_wdata = r11a_q;
  assign h_rd_valid = rdv_q;
  assign h_rd_data  = rdd_q;
  assign h_sel      = (st_q == ST_SUB) || (st_q == ST_WDATA) || (st_q == ST_RDATA);
endmodule

// File: rtl/ttx_reg_port.sv
module ttx_reg_port
  import ttx_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h11,
  parameter int NCHAP = 8,
  parameter int NROW  = 26,
  parameter int NCOL  = 40,
  localparam int CH_W  = (NCHAP > 1) ? $clog2(NCHAP) : 1,
  localparam int ROW_W = $clog2(NROW),
  localparam int COL_W = $clog2(NCOL),
  localparam int MAW   = CH_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_start,
  input  logic              h_stop,
  input  logic              h_wr_valid,
  input  logic [7:0]        h_wr_byte,
  output logic              h_wr_ready,
  input  logic              h_rd_req,
  output logic              h_rd_valid,
  output logic [7:0]        h_rd_data,
  output logic              h_sel,
  output logic [8*NCFG-1:0] cfg_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MAW-1:0]    mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  logic [1:0]       rs_q;
  logic             rst_sync_n;
  logic             fill_busy;
  logic [MAW-1:0]   fill_addr, host_addr;
  logic [7:0]       fill_wdata;
  logic             reg_we, col_adv;
  logic [IDX_W-1:0] reg_idx;
  logic [7:0]       reg_wdata;
  logic             host_req, host_we, host_ack;
  logic [7:0]       host_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  ttx_xfer_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n),
    .h_start(h_start), .h_stop(h_stop),
    .h_wr_valid(h_wr_valid), .h_wr_byte(h_wr_byte), .h_wr_ready(h_wr_ready),
    .h_rd_req(h_rd_req), .h_rd_valid(h_rd_valid), .h_rd_data(h_rd_data),
    .h_sel(h_sel),
    .mode_sel(cfg_o[8*IDX_MODE]), .fill_busy(fill_busy),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .host_req(host_req), .host_we(host_we), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(mem_rdata), .col_adv(col_adv)
  );

  ttx_reg_bank #(.NROW(NROW), .NCOL(NCOL)) bank_i (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(reg_we), .wr_idx(reg_idx), .wr_data(reg_wdata),
    .col_adv(col_adv), .cfg_flat(cfg_o)
  );

  ttx_mem_fill #(.NCHAP(NCHAP), .NROW(NROW), .NCOL(NCOL)) fill_i (
    .clk(clk), .rst_n(rst_sync_n), .ack(mem_ack),
    .busy(fill_busy), .addr(fill_addr), .wdata(fill_wdata)
  );

  assign host_addr = {cfg_o[8*IDX_CHAP +: CH_W],
                      cfg_o[8*IDX_ROW  +: ROW_W],
                      cfg_o[8*IDX_COL  +: COL_W]};
  assign host_ack  = mem_ack && !fill_busy;

  assign mem_req   = fill_busy ? 1'b1       : host_req;
  assign mem_we    = fill_busy ? 1'b1       : host_we;
  assign mem_addr  = fill_busy ? fill_addr  : host_addr;
  assign mem_wdata = fill_busy ? fill_wdata : host_wdata;
endmodule

// File: rtl/ttx_reg_port_chk.sv
module ttx_reg_port_chk
  import ttx_reg_pkg::*;
#(
  parameter int NCOL = 40,
  parameter int MAW  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fill_busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [MAW-1:0]    mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              mem_ack,
  input logic              h_rd_valid,
  input logic [8*NCFG-1:0] cfg_o
);
  function automatic logic [8*NCFG-1:0] reset_image();
    logic [8*NCFG-1:0] v;
    for (int i = 0; i < NCFG; i++) v[8*i +: 8] = reg_reset_val(i);
    return v;
  endfunction

  // R5: register image right after reset release
  a_r5_reset_image: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cfg_o == reset_image()));

  // R8: request fields hold until acknowledged
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R10: fill traffic carries only the two fill values
  a_r10_fill_values: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && mem_req) |-> (mem_we && (mem_wdata == 8'h20 || mem_wdata == 8'h07)));

  // R11: no host memory read is issued during the fill
  a_r11_no_read_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> mem_we);

  // R9: column wraps to zero after the last column
  a_r9_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_busy && mem_ack && cfg_o[8*IDX_COL +: 8] == 8'(NCOL - 1))
      |=> (cfg_o[8*IDX_COL +: 8] == 8'h00));

  // R3: read data strobe lasts one cycle
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_rd_valid |=> !h_rd_valid);
endmodule

bind ttx_reg_port ttx_reg_port_chk #(.NCOL(NCOL), .MAW(MAW)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .fill_busy(fill_busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .h_rd_valid(h_rd_valid), .cfg_o(cfg_o)
);

// File: tb/ttx_reg_port_tb_top.sv
`timescale 1ns/1ps
module ttx_reg_port_tb_top;
  localparam int NCHAP = 2;
  localparam int NROW  = 26;
  localparam int NCOL  = 40;
  localparam int MAW   = 1 + 5 + 6;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic h_start, h_stop, h_wr_valid, h_rd_req;
  logic [7:0] h_wr_byte;
  logic h_wr_ready, h_rd_valid, h_sel;
  logic [7:0] h_rd_data;
  logic [87:0] cfg_o;
  logic mem_req, mem_we, mem_ack;
  logic [MAW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] bmem [0:(1<<MAW)-1];

  int total = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ttx_reg_port #(.NCHAP(NCHAP), .NROW(NROW), .NCOL(NCOL)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_start(h_start), .h_stop(h_stop),
    .h_wr_valid(h_wr_valid), .h_wr_byte(h_wr_byte), .h_wr_ready(h_wr_ready),
    .h_rd_req(h_rd_req), .h_rd_valid(h_rd_valid), .h_rd_data(h_rd_data),
    .h_sel(h_sel), .cfg_o(cfg_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= 8'h00;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) bmem[mem_addr] <= mem_wdata;
        mem_rdata <= bmem[mem_addr];
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == LIMIT) begin
      fails = fails + 1;
      total = total + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int n);
    return cfg_o[8*n +: 8];
  endfunction

  function automatic int midx(input int ch, input int row, input int col);
    return ch * 2048 + row * 64 + col;
  endfunction

  task automatic bus_start();
    @(negedge clk); h_start = 1'b1;
    @(negedge clk); h_start = 1'b0;
  endtask

  task automatic bus_stop();
    @(negedge clk); h_stop = 1'b1;
    @(negedge clk); h_stop = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output int waited);
    waited = 0;
    @(negedge clk);
    h_wr_valid = 1'b1;
    h_wr_byte  = b;
    while (!h_wr_ready) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    h_wr_valid = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    int w;
    send_byte(b, w);
  endtask

  task automatic get(output logic [7:0] d);
    @(negedge clk);
    h_rd_req = 1'b1;
    do @(negedge clk); while (!h_rd_valid);
    d = h_rd_data;
    h_rd_req = 1'b0;
  endtask

  task automatic write_regs(input int ptr, input logic [7:0] b0, input int n);
    bus_start(); put(8'h22); put(8'(ptr));
    for (int i = 0; i < n; i++) put(b0);
    bus_stop();
  endtask

  task automatic t_reset();
    logic [87:0] exp;
    for (int i = 0; i < 11; i++) exp[8*i +: 8] = (i == 5 || i == 6) ? 8'h03 : 8'h00;
    check("R5 reset register image", 32'(cfg_o == exp), 32'd1);
    check("R1 h_sel idle after reset", 32'(h_sel), 32'd0);
  endtask

  task automatic t_status_busy();
    logic [7:0] d;
    write_regs(0, 8'h01, 1);
    check("R2 R0 written", 32'(reg_of(0)), 32'h01);
    bus_start(); put(8'h22); put(8'h0B);
    bus_start(); put(8'h23); get(d); bus_stop();
    check("R6 status shows fill busy", 32'(d), 32'h01);
  endtask

  task automatic t_hold_off();
    int w;
    write_regs(0, 8'h00, 1);
    bus_start(); put(8'h22); put(8'h08); put(8'h00); put(8'h00); put(8'h05);
    check("R11 register write during fill", 32'(reg_of(10)), 32'h05);
    send_byte(8'h5A, w);
    bus_stop();
    check("R11 data byte held off during fill", 32'(w > 100), 32'd1);
    repeat (6) @(negedge clk);
    check("R9 column advanced after access", 32'(reg_of(10)), 32'h06);
  endtask

  task automatic t_fill_image();
    int bad = 0;
    for (int ch = 0; ch < NCHAP; ch++)
      for (int r = 0; r < NROW; r++)
        for (int c = 0; c < NCOL; c++) begin
          logic [7:0] e;
          e = (ch == 0 && r == 0 && c == 7) ? 8'h07 :
              (ch == 0 && r == 0 && c == 5) ? 8'h5A : 8'h20;
          if (bmem[midx(ch, r, c)] !== e) bad++;
        end
    check("R10 fill image (held write landed after fill)", 32'(bad), 32'd0);
  endtask

  task automatic t_status_idle();
    logic [7:0] d;
    write_regs(0, 8'h01, 1);
    bus_start(); put(8'h22); put(8'h0B);
    bus_start(); put(8'h23); get(d); bus_stop();
    check("R6 status idle after fill", 32'(d), 32'h00);
    check("R6 status read leaves column", 32'(reg_of(10)), 32'h06);
  endtask

  task automatic t_write_wrap();
    bus_start(); put(8'h22); put(8'h08); put(8'h01); put(8'h02); put(8'h26);
    put(8'hAA); put(8'hBB); put(8'hCC);
    bus_stop();
    repeat (6) @(negedge clk);
    check("R7 write with status mode set", 32'(bmem[midx(1, 2, 38)]), 32'hAA);
    check("R9 last column written", 32'(bmem[midx(1, 2, 39)]), 32'hBB);
    check("R9 wrap to next row", 32'(bmem[midx(1, 3, 0)]), 32'hCC);
    check("R9 row register after wrap", 32'(reg_of(9)), 32'h03);
    check("R9 column register after wrap", 32'(reg_of(10)), 32'h01);
  endtask

  task automatic t_read_back();
    logic [7:0] d0, d1, d2;
    write_regs(0, 8'h00, 1);
    bus_start(); put(8'h22); put(8'h08); put(8'h01); put(8'h02); put(8'h26);
    bus_start(); put(8'h23); get(d0); get(d1); get(d2); bus_stop();
    check("R3 memory read first byte", 32'(d0), 32'hAA);
    check("R8 memory read second byte", 32'(d1), 32'hBB);
    check("R6 memory read after wrap", 32'(d2), 32'hCC);
  endtask

  task automatic t_auto_inc();
    bus_start(); put(8'h22); put(8'h01);
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55);
    bus_stop();
    check("R2 auto-increment R1", 32'(reg_of(1)), 32'h11);
    check("R2 auto-increment R3", 32'(reg_of(3)), 32'h33);
    check("R2 auto-increment R5", 32'(reg_of(5)), 32'h55);
    check("R2 R6 untouched", 32'(reg_of(6)), 32'h03);
  endtask

  task automatic t_write_only();
    logic [7:0] d0, d1;
    bus_start(); put(8'h22); put(8'h02);
    bus_start(); put(8'h23); get(d0); get(d1); bus_stop();
    check("R4 read of R2 returns zero", 32'(d0), 32'h00);
    check("R4 read of R3 returns zero", 32'(d1), 32'h00);
  endtask

  task automatic t_wrong_addr();
    logic s;
    bus_start(); put(8'h24);
    s = h_sel;
    put(8'h00); put(8'h77);
    bus_stop();
    check("R1 foreign address not selected", 32'(s), 32'd0);
    check("R1 foreign transfer leaves R0", 32'(reg_of(0)), 32'h00);
  endtask

  task automatic t_row_wrap();
    bus_start(); put(8'h22); put(8'h09); put(8'h19); put(8'h27); put(8'hEE);
    bus_stop();
    repeat (6) @(negedge clk);
    check("R9 last cell written", 32'(bmem[midx(1, 25, 39)]), 32'hEE);
    check("R9 row wraps to zero", 32'(reg_of(9)), 32'h00);
    check("R9 column wraps to zero", 32'(reg_of(10)), 32'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    h_start = 1'b0; h_stop = 1'b0; h_wr_valid = 1'b0; h_wr_byte = 8'h00; h_rd_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status_busy();
    t_hold_off();
    repeat (10) @(negedge clk);
    t_fill_image();
    t_status_idle();
    t_write_wrap();
    t_read_back();
    t_auto_inc();
    t_write_only();
    t_wrong_addr();
    t_row_wrap();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule